// File: doc/BRIEF.md
# Clocked Transfer-Start / Transfer-Acknowledge Bus Slave

This block is a register slave on a synchronous processor bus. Every signal is sampled on the rising edge of one clock. A master opens a transaction by raising a start strobe for one clock. On that same edge it presents a 24-bit byte address, a direction line and a two-bit size code. The slave captures these fields at that edge. It then waits a fixed number of wait states, set by a parameter, by holding back its acknowledge. Finally it raises the acknowledge for one clock.

- **Read:** the full 32-bit register word is placed on the read bus in the cycle where the acknowledge is high.
- **Write:** the write bus is captured on the edge where the master sees the acknowledge. Only the byte lanes chosen by the size code and the two low address bits are updated. Lane 0 (bits 31:24) carries the lowest-addressed byte.

The bus carries its own flow control: the master holds the request until the acknowledge arrives. The slave provides no valid/ready pair and no other handshake. The slave answers only to a window of addresses fixed by a base parameter. Outside that window it stays silent, because another slave on the bus is expected to respond.

Top module: `ts_ta_slave`

## Requirements
- R1: After reset, `xfer_ack` is 0, `rdata` is 0, and every register reads back as 0.
- R2: A transaction starts only on an edge where `xfer_start` is 1, `addr[23:4]` equals the base window `BASE_ADDR[23:4]`, and no transaction is waiting. A start strobe seen while waiting is ignored and produces no extra acknowledge. An address outside the window is never acknowledged.
- R3: `xfer_ack` is high for exactly one cycle per transaction. It is sampled high on the edge `WAIT_STATES+1` clocks after the start edge, so the minimum transaction is two clocks.
- R4: While wait states are being counted, `xfer_ack` stays low.
- R5: On a read (`rd_nwr`=1), `rdata` holds the full word of register `addr[3:2]` in the cycle `xfer_ack` is high. In every other cycle `rdata` is 0.
- R6: A write (`rd_nwr`=0) takes `wdata` on the edge where `xfer_ack` is high. Each selected byte lane k (lane 0 = bits 31:24 = byte offset 0, lane 3 = bits 7:0 = offset 3) replaces that byte of the register. Lanes that are not selected keep their value.
- R7: Size code 01 is a byte at offset `addr[1:0]`. Size code 10 is a halfword and needs `addr[0]`=0. Size codes 00 and 11 are a word and need `addr[1:0]`=0. A misaligned write is still acknowledged but changes no register.
- R8: A new start may arrive on the edge where the previous acknowledge is sampled. A read launched on that edge returns the value just written by the transaction completing there.
- R9: Address, direction and size are taken from the start edge. Changes on those inputs during wait states do not affect the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | One-cycle transaction start strobe |
| addr | input | 24 | Byte address, valid with the strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| size | input | 2 | 00 word, 01 byte, 10 halfword, 11 word |
| wdata | input | 32 | Write data, lane 0 in bits 31:24 |
| rdata | output | 32 | Read data, valid while acknowledge is high |
| xfer_ack | output | 1 | One-cycle transfer acknowledge |

## Verification
The delicate coincidence is a write being committed on the same edge that a following read is launched. This is provoked by raising the start strobe in the very cycle the write's acknowledge is seen, on an instance with zero wait states, so that the read data is loaded on that same edge. The read is judged correct only if it returns the freshly merged word rather than the stale one. A second instance with three wait states checks that stray strobes and address changes during the wait leave the pending transaction untouched.

// File: rtl/ts_ta_pkg.sv
package ts_ta_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_WRD2 = 2'b11
  } xfer_size_e;

  localparam int unsigned LANES = 4;

  // bit k selects byte lane k; lane 0 is data[31:24] (lowest address)
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz,
                                                 input logic [1:0] off);
    logic [LANES-1:0] m;
    unique case (sz)
      SZ_BYTE: m = 4'b0001 << off;
      SZ_HALF: m = off[0] ? 4'b0000 : (4'b0011 << off);
      default: m = (off == 2'b00) ? 4'b1111 : 4'b0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ts_ta_ctrl.sv
module ts_ta_ctrl #(
  parameter int unsigned WAIT_STATES = 1,
  parameter int unsigned AW          = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          in_window,
  input  logic [AW-1:0] addr_in,
  input  logic          rd_in,
  input  logic [1:0]    size_in,
  output logic          fire,
  output logic [AW-1:0] cur_addr,
  output logic          cur_rd,
  output logic [AW-1:0] hold_addr,
  output logic          hold_rd,
  output logic [1:0]    hold_size,
  output logic          ack
);

  localparam int unsigned CW   = (WAIT_STATES < 2) ? 1 : $clog2(WAIT_STATES);
  localparam logic [CW-1:0] LOAD = CW'((WAIT_STATES == 0) ? 0 : WAIT_STATES - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          start;

  assign start    = strobe && in_window && !busy;
  assign fire     = (start && (WAIT_STATES == 0)) || (busy && (cnt == '0));
  assign cur_addr = start ? addr_in : hold_addr;
  assign cur_rd   = start ? rd_in   : hold_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      ack       <= 1'b0;
      hold_addr <= '0;
      hold_rd   <= 1'b0;
      hold_size <= 2'b00;
    end else begin
      ack <= fire;
      if (start) begin
        hold_addr <= addr_in;
        hold_rd   <= rd_in;
        hold_size <= size_in;
        if (WAIT_STATES != 0) begin
          busy <= 1'b1;
          cnt  <= LOAD;
        end
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  p_quiet_while_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack);

  p_single_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !$past(start)) |=> !ack);

  p_busy_ignores_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && strobe && cnt != '0) |=> $stable(hold_addr));

endmodule

// File: rtl/ts_ta_lanes.sv
module ts_ta_lanes
  import ts_ta_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  offset,
  input  logic [31:0] old_word,
  input  logic [31:0] new_data,
  output logic [31:0] merged
);

  logic [LANES-1:0] mask;
  assign mask = lane_mask(size, offset);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[31-8*k -: 8] = mask[k] ? new_data[31-8*k -: 8]
                                          : old_word[31-8*k -: 8];
  end

  always_comb begin
    p_mask_shape_r7: assert ($countones(mask) != 3);
  end

endmodule

// File: rtl/ts_ta_regbank.sv
module ts_ta_regbank #(
  parameter int unsigned NREGS = 4,
  localparam int unsigned IW   = (NREGS < 2) ? 1 : $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wword,
  input  logic [IW-1:0] ridx_a,
  output logic [31:0]   rword_a,
  input  logic [IW-1:0] ridx_b,
  output logic [31:0]   rword_b
);

  logic [31:0] mem [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                              mem[i] <= '0;
      else if (we && widx == IW'(i))           mem[i] <= wword;
    end

    p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && widx == IW'(i)) |=> $stable(mem[i]));
  end

  assign rword_a = mem[ridx_a];
  assign rword_b = mem[ridx_b];

endmodule

// File: rtl/ts_ta_slave.sv
module ts_ta_slave
  import ts_ta_pkg::*;
#(
  parameter int unsigned NREGS       = 4,
  parameter int unsigned WAIT_STATES = 1,
  parameter logic [23:0] BASE_ADDR   = 24'h000100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_start,
  input  logic [23:0] addr,
  input  logic        rd_nwr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        xfer_ack
);

  localparam int unsigned IW = (NREGS < 2) ? 1 : $clog2(NREGS);
  localparam int unsigned LO = IW + 2;

  logic          in_window, fire, cur_rd, hold_rd, we;
  logic [23:0]   cur_addr, hold_addr;
  logic [1:0]    hold_size;
  logic [IW-1:0] widx, ridx;
  logic [31:0]   old_word, merged, rd_word, fwd_word;

  assign in_window = (addr[23:LO] == BASE_ADDR[23:LO]);

  ts_ta_ctrl #(.WAIT_STATES(WAIT_STATES), .AW(24)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe(xfer_start), .in_window(in_window),
    .addr_in(addr), .rd_in(rd_nwr), .size_in(size),
    .fire(fire), .cur_addr(cur_addr), .cur_rd(cur_rd),
    .hold_addr(hold_addr), .hold_rd(hold_rd), .hold_size(hold_size),
    .ack(xfer_ack)
  );

  // write commits on the edge where the master samples the acknowledge
  assign we   = xfer_ack && !hold_rd;
  assign widx = hold_addr[LO-1:2];
  assign ridx = cur_addr[LO-1:2];

  ts_ta_lanes u_lanes (
    .size(hold_size), .offset(hold_addr[1:0]),
    .old_word(old_word), .new_data(wdata), .merged(merged)
  );

  ts_ta_regbank #(.NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wword(merged),
    .ridx_a(widx), .rword_a(old_word),
    .ridx_b(ridx), .rword_b(rd_word)
  );

  // a read launched on the commit edge must see the committed word
  assign fwd_word = (we && widx == ridx) ? merged : rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n)              rdata <= '0;
    else if (fire && cur_rd) rdata <= fwd_word;
    else                     rdata <= '0;
  end

  p_rdata_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ack |-> rdata == '0);

  p_no_ack_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !in_window && !xfer_ack && WAIT_STATES == 0) |=> !xfer_ack);

endmodule

// File: tb/ts_ta_slave_bench.sv
module ts_ta_slave_bench;

  localparam logic [23:0] BASE = 24'h000100;

  logic        clk = 0, rst_n = 0;
  logic        ts = 0, rd = 0, sel = 0;
  logic [23:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b, rdata_m;
  logic        ack_a, ack_b, ack_m;
  int          checks = 0, errors = 0;
  logic [31:0] mdl [2][4];

  always #2.5 clk = ~clk;

  ts_ta_slave #(.WAIT_STATES(0), .BASE_ADDR(BASE)) u_ts_ta_slave (
    .clk(clk), .rst_n(rst_n), .xfer_start(ts & ~sel), .addr(addr),
    .rd_nwr(rd), .size(size), .wdata(wdata), .rdata(rdata_a), .xfer_ack(ack_a));

  ts_ta_slave #(.WAIT_STATES(3), .BASE_ADDR(BASE)) u_ts_ta_slave_w3 (
    .clk(clk), .rst_n(rst_n), .xfer_start(ts & sel), .addr(addr),
    .rd_nwr(rd), .size(size), .wdata(wdata), .rdata(rdata_b), .xfer_ack(ack_b));

  assign ack_m   = sel ? ack_b : ack_a;
  assign rdata_m = sel ? rdata_b : rdata_a;

  function automatic int waits();
    return sel ? 3 : 0;
  endfunction

  function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [31:0] nw,
                                            input logic [1:0] sz, input logic [1:0] off);
    int n = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
    logic [31:0] r = old;
    if ((int'(off) % n) != 0) return old;
    for (int b = int'(off); b < int'(off) + n; b++)
      r[31-8*b -: 8] = nw[31-8*b -: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (inst %0d)", req, act, exp, sel);
    end
  endtask

  task automatic xfer(input logic [23:0] a, input logic r, input logic [1:0] sz,
                      input logic [31:0] wd, input bit mess);
    int n;
    bit hit = (a[23:4] == BASE[23:4]);
    logic [1:0] idx = a[3:2];
    @(negedge clk);
    ts = 1; addr = a; rd = r; size = sz; wdata = wd;
    @(negedge clk);
    ts = 0; n = 1;
    if (!hit) begin
      for (int i = 0; i < waits() + 3; i++) begin
        chk(ack_m == 0, "R2 out-of-window ack", 32'(ack_m), 0);
        @(negedge clk);
      end
      return;
    end
    if (mess && sel && !ack_m) begin
      ts = 1; addr = a ^ 24'h4; rd = ~r; size = ~sz;
    end
    while (ack_m !== 1'b1 && n < 20) begin
      @(negedge clk); ts = 0; n++;
    end
    chk(n == waits() + 1, "R3/R4 ack latency", 32'(n), 32'(waits() + 1));
    if (r) chk(rdata_m == mdl[sel][idx], mess ? "R9 read held fields" : "R5 read data",
               rdata_m, mdl[sel][idx]);
    else   mdl[sel][idx] = exp_merge(mdl[sel][idx], wd, sz, a[1:0]);
    @(negedge clk);
    chk(ack_m == 0, "R3 ack one cycle", 32'(ack_m), 0);
    chk(rdata_m == 0, "R5 rdata idle zero", rdata_m, 0);
    if (mess) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(ack_m == 0, "R2 stray strobe ignored", 32'(ack_m), 0);
      end
    end
  endtask

  task automatic b2b(input logic [23:0] a, input logic [31:0] wd);
    int n;
    @(negedge clk);
    ts = 1; addr = a; rd = 0; size = 2'b00; wdata = wd;
    @(negedge clk);
    ts = 0; n = 1;
    while (ack_m !== 1'b1 && n < 20) begin @(negedge clk); n++; end
    chk(n == waits() + 1, "R8 write latency", 32'(n), 32'(waits() + 1));
    mdl[sel][a[3:2]] = wd;
    ts = 1; rd = 1;
    @(negedge clk);
    ts = 0; n = 1;
    while (ack_m !== 1'b1 && n < 20) begin @(negedge clk); n++; end
    chk(n == waits() + 1, "R8 chained read latency", 32'(n), 32'(waits() + 1));
    chk(rdata_m == wd, "R8 forwarded read", rdata_m, wd);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 2; s++) for (int i = 0; i < 4; i++) mdl[s][i] = '0;
    repeat (3) @(negedge clk);
    chk(ack_a == 0 && ack_b == 0, "R1 reset ack", 32'(ack_a | ack_b), 0);
    chk(rdata_a == 0 && rdata_b == 0, "R1 reset rdata", rdata_a | rdata_b, 0);
    rst_n = 1;
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      for (int i = 0; i < 4; i++) xfer(BASE + 24'(4*i), 1, 2'b00, 0, 0);   // R1 read zeros
      // R6/R7 directed lanes
      xfer(BASE + 24'h4, 0, 2'b00, 32'h12345678, 0);
      xfer(BASE + 24'h5, 0, 2'b01, 32'hAABBCCDD, 0);
      xfer(BASE + 24'h6, 0, 2'b10, 32'h11223344, 0);
      xfer(BASE + 24'h5, 0, 2'b10, 32'hFFFFFFFF, 0);   // R7 misaligned half
      xfer(BASE + 24'h6, 0, 2'b11, 32'hEEEEEEEE, 0);   // R7 misaligned word
      xfer(BASE + 24'h4, 1, 2'b00, 0, 0);
      xfer(24'h000200, 1, 2'b00, 0, 0);                // R2 outside window
      xfer(BASE + 24'h8, 0, 2'b00, 32'hCAFEF00D, 0);
      xfer(BASE + 24'h8, 1, 2'b00, 0, 1);              // R9 / R2 stray strobe
      b2b(BASE + 24'hC, 32'h5A5A0FF0);                 // R8
      b2b(BASE + 24'hC, 32'h0123ABCD);
      for (int i = 0; i < 150; i++) begin
        logic [23:0] a = BASE + 24'($urandom_range(0, 15));
        if ($urandom_range(0, 9) == 0) a[23:4] = 20'($urandom);
        xfer(a, 1'($urandom), 2'($urandom), $urandom, 1'($urandom_range(0, 7) == 0));
      end
      for (int i = 0; i < 4; i++) xfer(BASE + 24'(4*i), 1, 2'b00, 0, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule